// File: doc/BRIEF.md
# PTP Transmit Frame Buffer

This block is a byte-wide dual-port store for timing-protocol frames prepared in advance by software. The store is cut into eight fixed slots of 256 bytes. In each slot, offset 0 gives the number of bytes to send. Offsets 1 to 7 are spare. The frame itself starts at offset 8 and runs from the destination address onwards, with no padding and no CRC, because those are added further down the transmit path. Offsets 0xFC to 0xFF receive the 32-bit transmit time. A host register port can read and write every byte of every slot.

To send frames, the host writes a request mask with one bit per slot. Pending slots are served in order of index, lowest first. For each slot the block checks the length byte and then streams the frame bytes over a valid/ready byte interface, marking the final byte with a last flag. It latches the free-running real-time counter on the first accepted beat. Once the last beat has been accepted, it writes that value back into the slot's trailer and retires the request. A length that is out of range drops the request and raises a sticky per-slot error bit.

Top module: `ptp_txbuf`

## Requirements
- R1: After reset, every pending bit and every error bit is 0, and tx_valid is low.
- R2: The host port writes any byte address (slot index in address bits [10:8], offset in bits [7:0]) when host_we is high. host_rdata returns the byte at host_addr one clock after the address is presented.
- R3: A req_we pulse ORs req_mask into the pending bits, which appear on pend_o (bit n means slot n) in the next cycle. When several bits are pending, the lowest-numbered slot is served first.
- R4: For a valid length L, exactly L beats are sent, carrying the slot bytes at offsets 8 to 8+L-1 in increasing order. tx_last is high on the final beat only.
- R5: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R6: A length of 0 or above 244 sends no beat, clears the slot's pending bit and sets the slot's bit in err_o. That error bit clears when the host requests the same slot again.
- R7: The value on rtc_i at the clock edge that accepts the first beat is written back least significant byte first, at offsets 0xFC (bits 7:0) through 0xFF (bits 31:24). The pending bit clears once the last trailer byte has been written.
- R8: When a host write and a trailer write target the same byte in the same clock, the host data is stored.
- R9: The block never alters offsets 0 to 7 of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 11 | Host byte address {slot, offset} |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after address |
| req_we | input | 1 | Request mask write strobe |
| req_mask | input | 8 | Slots to add to the pending set |
| pend_o | output | 8 | Pending request bits per slot |
| err_o | output | 8 | Sticky length-error bits per slot |
| rtc_i | input | 32 | Free-running real-time counter |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data holds a beat |
| tx_ready | input | 1 | Sink accepts the beat this cycle |
| tx_last | output | 1 | Marks the final byte of a frame |

## Verification
If the byte pointer or remaining count goes wrong, it shows as a wrong byte or a misplaced tx_last within the frame that contains the error, and the bench compares every beat with the bytes it wrote. A timestamp latched at the wrong beat shows up in the trailer readback a few cycles after the frame ends. A stuck or miscleared pending bit shows as a missing frame, a wrong serving order or a hang, which the bench catches when it waits for the pending set to drain. A trailer write that is misplaced or wins a collision shows up when the bench reads back the trailer or the spare bytes.

// File: rtl/ptp_txbuf_pkg.sv
package ptp_txbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEN,
    ST_STREAM,
    ST_STAMP
  } eng_state_t;
endpackage

// File: rtl/ptp_txbuf_mem.sv
// Byte store with two ports. Port A belongs to the host and port B to the engine.
// A host write takes precedence over an engine write to the same byte.
module ptp_txbuf_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_re,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_re) b_rdata <= mem[b_addr];
    if (b_we && !(a_we && (a_addr == b_addr))) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/ptp_txbuf_req.sv
// Holds the pending and error bits for each slot and picks the lowest pending slot.
module ptp_txbuf_req #(
  parameter int SLOTS = 8,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic [SLOTS-1:0] set_mask,
  input  logic             done,
  input  logic             bad,
  input  logic [IW-1:0]    fin_idx,
  output logic [SLOTS-1:0] pend,
  output logic [SLOTS-1:0] err,
  output logic             pick_vld,
  output logic [IW-1:0]    pick_idx
);
  logic [SLOTS-1:0] fin_oh, bad_oh, set_v;

  assign fin_oh = (done || bad) ? (SLOTS'(1) << fin_idx) : '0;
  assign bad_oh = bad ? (SLOTS'(1) << fin_idx) : '0;
  assign set_v  = set_we ? set_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      err  <= '0;
    end else begin
      pend <= (pend & ~fin_oh) | set_v;
      err  <= (err & ~set_v) | bad_oh;
    end
  end

  always_comb begin
    pick_vld = |pend;
    pick_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend[i]) pick_idx = IW'(i);
    end
  end
endmodule

// File: rtl/ptp_txbuf_eng.sv
// Transmit engine: reads and checks the length, streams the frame bytes,
// latches the timestamp on the first beat and writes it into the slot trailer.
module ptp_txbuf_eng
  import ptp_txbuf_pkg::*;
#(
  parameter int IW       = 3,
  parameter int OFF_W    = 8,
  parameter int TS_W     = 32,
  parameter int DATA_OFF = 8,
  parameter int TS_OFF   = 252,
  parameter int MAX_LEN  = 244
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pick_vld,
  input  logic [IW-1:0]    pick_idx,
  input  logic [TS_W-1:0]  rtc,
  output logic             mem_re,
  output logic             mem_we,
  output logic [IW+OFF_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_q,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic             done,
  output logic             bad,
  output logic [IW-1:0]    slot_idx
);
  localparam int TSB = TS_W / 8;
  localparam int BKW = (TSB > 1) ? $clog2(TSB) : 1;
  localparam logic [BKW-1:0] BK_LAST = BKW'(TSB - 1);

  eng_state_t        state;
  logic [IW-1:0]     slot_q;
  logic [OFF_W-1:0]  ptr, remain;
  logic [TS_W-1:0]   ts_q;
  logic [BKW-1:0]    bk;
  logic              first_q;
  logic              len_bad;

  assign len_bad  = (mem_q == 8'd0) || (int'(mem_q) > MAX_LEN);
  assign tx_valid = (state == ST_STREAM);
  assign tx_last  = (state == ST_STREAM) && (remain == OFF_W'(1));
  assign slot_idx = slot_q;

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {slot_q, ptr};
    mem_wdata = ts_q[bk*8 +: 8];
    done      = 1'b0;
    bad       = 1'b0;
    case (state)
      ST_IDLE: if (pick_vld) begin
        mem_re   = 1'b1;
        mem_addr = {pick_idx, OFF_W'(0)};
      end
      ST_LEN: begin
        if (len_bad) bad = 1'b1;
        else begin
          mem_re   = 1'b1;
          mem_addr = {slot_q, OFF_W'(DATA_OFF)};
        end
      end
      ST_STREAM: if (tx_ready && (remain != OFF_W'(1))) mem_re = 1'b1;
      ST_STAMP: begin
        mem_we   = 1'b1;
        mem_addr = {slot_q, OFF_W'(TS_OFF) + OFF_W'(bk)};
        done     = (bk == BK_LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      slot_q  <= '0;
      ptr     <= '0;
      remain  <= '0;
      ts_q    <= '0;
      bk      <= '0;
      first_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (pick_vld) begin
          slot_q <= pick_idx;
          state  <= ST_LEN;
        end
        ST_LEN: begin
          if (len_bad) state <= ST_IDLE;
          else begin
            remain  <= OFF_W'(mem_q);
            ptr     <= OFF_W'(DATA_OFF + 1);
            first_q <= 1'b1;
            state   <= ST_STREAM;
          end
        end
        ST_STREAM: if (tx_ready) begin
          first_q <= 1'b0;
          if (first_q) ts_q <= rtc;
          if (remain == OFF_W'(1)) begin
            bk    <= '0;
            state <= ST_STAMP;
          end else begin
            remain <= remain - OFF_W'(1);
            ptr    <= ptr + OFF_W'(1);
          end
        end
        ST_STAMP: begin
          bk <= bk + BKW'(1);
          if (bk == BK_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptp_txbuf.sv
module ptp_txbuf #(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 256,
  parameter int TS_W       = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   host_we,
  input  logic [$clog2(SLOTS*SLOT_BYTES)-1:0]    host_addr,
  input  logic [7:0]                             host_wdata,
  output logic [7:0]                             host_rdata,
  input  logic                                   req_we,
  input  logic [SLOTS-1:0]                       req_mask,
  output logic [SLOTS-1:0]                       pend_o,
  output logic [SLOTS-1:0]                       err_o,
  input  logic [TS_W-1:0]                        rtc_i,
  output logic [7:0]                             tx_data,
  output logic                                   tx_valid,
  input  logic                                   tx_ready,
  output logic                                   tx_last
);
  localparam int IW       = $clog2(SLOTS);
  localparam int OFF_W    = $clog2(SLOT_BYTES);
  localparam int AW       = IW + OFF_W;
  localparam int DATA_OFF = 8;
  localparam int TS_OFF   = SLOT_BYTES - TS_W / 8;
  localparam int MAX_LEN  = TS_OFF - DATA_OFF;

  logic          eng_re, eng_we, eng_done, eng_bad, pick_vld;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata, eng_q;
  logic [IW-1:0] pick_idx, eng_slot;

  ptp_txbuf_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .a_we(host_we), .a_addr(host_addr), .a_wdata(host_wdata),
    .a_rdata(host_rdata), .b_re(eng_re), .b_we(eng_we), .b_addr(eng_addr),
    .b_wdata(eng_wdata), .b_rdata(eng_q)
  );

  ptp_txbuf_req #(.SLOTS(SLOTS), .IW(IW)) u_req (
    .clk(clk), .rst(rst), .set_we(req_we), .set_mask(req_mask),
    .done(eng_done), .bad(eng_bad), .fin_idx(eng_slot),
    .pend(pend_o), .err(err_o), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  ptp_txbuf_eng #(
    .IW(IW), .OFF_W(OFF_W), .TS_W(TS_W), .DATA_OFF(DATA_OFF),
    .TS_OFF(TS_OFF), .MAX_LEN(MAX_LEN)
  ) u_eng (
    .clk(clk), .rst(rst), .pick_vld(pick_vld), .pick_idx(pick_idx), .rtc(rtc_i),
    .mem_re(eng_re), .mem_we(eng_we), .mem_addr(eng_addr), .mem_wdata(eng_wdata),
    .mem_q(eng_q), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .done(eng_done), .bad(eng_bad), .slot_idx(eng_slot)
  );

  assign tx_data = eng_q;
endmodule

// File: rtl/ptp_txbuf_chk.sv
module ptp_txbuf_chk #(
  parameter int SLOTS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [SLOTS-1:0] pend_o,
  input logic [SLOTS-1:0] err_o,
  input logic [7:0]       tx_data,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_last,
  input logic             eng_we
);
  // R1: outputs are idle in the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && pend_o == '0 && err_o == '0));

  // R5: a stalled beat is held unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R3: a beat goes out only while some request is pending
  a_r3_stream_pending: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (pend_o != '0));

  // R3: at most one request retires per cycle
  a_r3_one_retire: assert property (@(posedge clk) disable iff (rst)
    $countones($past(pend_o) & ~pend_o) <= 1);

  // R6: at most one error bit rises per cycle
  a_r6_one_err: assert property (@(posedge clk) disable iff (rst)
    $countones(err_o & ~$past(err_o)) <= 1);

  // R7: trailer writes never overlap streaming
  a_r7_wb_after_stream: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !tx_valid);
endmodule

bind ptp_txbuf ptp_txbuf_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .pend_o(pend_o), .err_o(err_o), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .eng_we(eng_we)
);

// File: tb/ptp_txbuf_bench.sv
module ptp_txbuf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        req_we = 1'b0;
  logic [7:0]  req_mask = '0;
  logic [7:0]  pend_o, err_o;
  logic [31:0] rtc = 32'h1000_0000;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;

  int checks = 0, fails = 0, cyc = 0, stall = 0, rx_n = 0;
  logic [7:0]  rx_data [0:1023];
  logic        rx_last [0:1023];
  logic [31:0] rx_ts;
  bit          done_flag = 0;

  // {slot, length, seed, stall mode}
  localparam logic [31:0] VEC [5] = '{
    {8'd0, 8'd5,   8'h10, 8'd0},
    {8'd3, 8'd1,   8'h30, 8'd1},
    {8'd7, 8'd244, 8'h70, 8'd0},
    {8'd4, 8'd60,  8'h40, 8'd2},
    {8'd6, 8'd17,  8'h60, 8'd1}
  };

  ptp_txbuf u_ptp_txbuf (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_we(req_we),
    .req_mask(req_mask), .pend_o(pend_o), .err_o(err_o), .rtc_i(rtc),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
  );

  always #5 clk = ~clk;
  always @(posedge clk) rtc <= rtc + 32'd1;

  // Drives tx_ready and records every beat the next edge will accept.
  always @(negedge clk) begin
    logic r;
    cyc++;
    case (stall)
      1: r = cyc[0];
      2: r = (cyc % 3 == 0);
      default: r = 1'b1;
    endcase
    tx_ready = r;
    if (tx_valid && r && rx_n < 1024) begin
      if (rx_n == 0) rx_ts = rtc;
      rx_data[rx_n] = tx_data;
      rx_last[rx_n] = tx_last;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic request(input logic [7:0] m);
    @(negedge clk);
    req_we = 1'b1; req_mask = m;
    @(negedge clk);
    req_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pend_o == 8'd0) break;
    end
    @(negedge clk);
  endtask

  task automatic load(input int slot, input int len, input logic [7:0] seed);
    hwr(11'(slot * 256), 8'(len));
    for (int j = 1; j < 8; j++) hwr(11'(slot * 256 + j), 8'(8'hE0 + j));
    for (int j = 0; j < len && j < 244; j++) hwr(11'(slot * 256 + 8 + j), 8'(seed + j));
  endtask

  task automatic check_ts(input int slot, input logic [31:0] exp, input string req);
    logic [31:0] got;
    logic [7:0]  b;
    for (int k = 0; k < 4; k++) begin
      hrd(11'(slot * 256 + 252 + k), b);
      got[k*8 +: 8] = b;
    end
    chk(got == exp, req, "trailer timestamp", got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pend_o == 0 && err_o == 0 && !tx_valid, "R1", "reset outputs",
        {pend_o, err_o, 7'd0, tx_valid}, 0);

    // R2 host access, including the top address
    hwr(11'h7FF, 8'h5C);
    hrd(11'h7FF, b);
    chk(b == 8'h5C, "R2", "host readback top", b, 8'h5C);
    hwr(11'h123, 8'h9A);
    hrd(11'h123, b);
    chk(b == 8'h9A, "R2", "host readback mid", b, 8'h9A);

    // Table-driven frames: R4 data and last, R7 timestamp, R9 spare bytes
    foreach (VEC[v]) begin
      int slot = int'(VEC[v][31:24]);
      int len  = int'(VEC[v][23:16]);
      logic [7:0] seed = VEC[v][15:8];
      load(slot, len, seed);
      stall = int'(VEC[v][7:0]);
      rx_n = 0;
      request(8'(1 << slot));
      wait_idle();
      chk(rx_n == len, "R4", "beat count", rx_n, len);
      ok = 1;
      for (int j = 0; j < rx_n && j < len; j++)
        if (rx_data[j] != 8'(seed + j) || rx_last[j] != (j == len - 1)) ok = 0;
      chk(ok, "R4", "frame bytes and last flag", ok, 1);
      check_ts(slot, rx_ts, "R7");
      ok = 1;
      for (int j = 0; j < 8; j++) begin
        hrd(11'(slot * 256 + j), b);
        if (b != ((j == 0) ? 8'(len) : 8'(8'hE0 + j))) ok = 0;
      end
      chk(ok, "R9", "header bytes untouched", ok, 1);
    end
    stall = 0;

    // R3 lowest slot first, pending visible next cycle
    load(5, 3, 8'h50);
    load(2, 3, 8'h20);
    rx_n = 0;
    @(negedge clk);
    req_we = 1'b1; req_mask = 8'h24;
    @(negedge clk);
    req_we = 1'b0;
    chk(pend_o == 8'h24, "R3", "pending mask", pend_o, 8'h24);
    wait_idle();
    chk(rx_n == 6 && rx_data[0] == 8'h20 && rx_data[3] == 8'h50, "R3",
        "service order", {rx_data[0], rx_data[3]}, 16'h2050);

    // R6 zero length and over-long length
    load(1, 0, 8'h00);
    rx_n = 0;
    request(8'h02);
    wait_idle();
    chk(err_o == 8'h02 && rx_n == 0, "R6", "zero length dropped", {err_o, 8'(rx_n)}, 16'h0200);
    hwr(11'(6 * 256), 8'd245);
    request(8'h40);
    wait_idle();
    chk(err_o == 8'h42 && rx_n == 0 && pend_o == 0, "R6", "length 245 dropped",
        {err_o, 8'(rx_n)}, 16'h4200);
    load(1, 2, 8'hA0);
    request(8'h02);
    chk(err_o == 8'h40, "R6", "error clears on re-request", err_o, 8'h40);
    wait_idle();
    chk(rx_n == 2 && rx_data[0] == 8'hA0 && rx_data[1] == 8'hA1, "R6",
        "re-requested slot sent", rx_n, 2);

    // R8 host write collides with the trailer write of offset 0xFD
    load(2, 2, 8'h33);
    rx_n = 0;
    request(8'h04);
    do @(negedge clk); while (!(tx_valid && tx_last));
    @(negedge clk);
    @(negedge clk);
    host_we = 1'b1; host_addr = 11'(2 * 256 + 253); host_wdata = 8'hA5;
    @(negedge clk);
    host_we = 1'b0;
    wait_idle();
    check_ts(2, {rx_ts[31:16], 8'hA5, rx_ts[7:0]}, "R8");

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule